// File: doc/BRIEF.md
# Dual-Mode Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the 32-bit product into an accumulator that is split into a high word and a low word. A mode input picks one of two accumulation styles. In wide mode the two words form one 42-bit signed sum. In clamped mode only the low word holds the sum, which is limited to the signed 32-bit range, and bit 0 of the high word records that a clamp happened.

Software can load either accumulator word, or both operand pointers, through write strobes, and it reads all of them back on the outputs. Each accepted accumulate request steps both 32-bit operand address pointers forward by two, so a caller that fetches operands from memory can walk two arrays in step. Fetching the operands from memory is not part of this block.

Top module: `mac_unit`

## Requirements
- R1: When `acc_valid` is high and no write strobe is high, the product of `op_a` and `op_b` (both signed two's-complement) is added into the accumulator at that clock edge, and `done` is high for exactly the one cycle that follows.
- R2: In wide mode (`sat_mode`=0) the sum is a 42-bit signed value: bits 31:0 go to `acc_lo`, bits 41:32 go to `acc_hi[9:0]`, and `acc_hi[31:10]` are all copies of bit 41. The sum wraps modulo 2^42.
- R3: In clamped mode (`sat_mode`=1) `acc_lo` becomes the signed sum of the old `acc_lo` and the product, limited to 0x80000000 below and 0x7FFFFFFF above, and `acc_hi[31:1]` keep their previous values.
- R4: In clamped mode `acc_hi[0]` is set by any accumulate whose sum falls outside the signed 32-bit range and stays set through later clamped-mode accumulates; it is changed only by a high-word write or by a wide-mode accumulate.
- R5: Each accepted accumulate adds 2 to both `ptr_a` and `ptr_b`, wrapping modulo 2^32.
- R6: `hi_we` loads `wdata` into `acc_hi`, `lo_we` loads `wdata` into `acc_lo`, and `ptr_we` loads `ptr_a_wdata` and `ptr_b_wdata` into the pointers. If any of these strobes is high in the same cycle as `acc_valid`, the write is done and the accumulate is dropped: no accumulator change from the product, no pointer step and no `done`.
- R7: After reset both accumulator words and both pointers are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sat_mode | input | 1 | 1 selects clamped 32-bit mode, 0 selects wide 42-bit mode |
| acc_valid | input | 1 | Accumulate request |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| hi_we | input | 1 | Load `wdata` into the high word |
| lo_we | input | 1 | Load `wdata` into the low word |
| wdata | input | 32 | Data for accumulator word writes |
| ptr_we | input | 1 | Load both operand pointers |
| ptr_a_wdata | input | 32 | New value of pointer A |
| ptr_b_wdata | input | 32 | New value of pointer B |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |
| ptr_a | output | 32 | Operand pointer A |
| ptr_b | output | 32 | Operand pointer B |
| done | output | 1 | One-cycle pulse after an accepted accumulate |

## Verification
Every result of this block is due one clock edge after its stimulus: the accumulator words, the pointers and `done` all change at the edge that samples `acc_valid` or a write strobe, and `done` falls again at the following edge. The bench drives inputs just after a falling edge, lets one rising edge pass and reads the outputs at the next falling edge, then reads `done` once more a cycle later to confirm the pulse is a single cycle. Cancelled accumulates are checked the same way, by reading the words, pointers and `done` one cycle after the colliding write.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OP_W    = 16;
  localparam int PROD_W  = 2 * OP_W;
  localparam int WORD_W  = 32;
  localparam int WIDE_W  = 42;
  localparam int HI_BITS = WIDE_W - WORD_W;
  localparam int EXT_W   = 2 * WORD_W - WIDE_W;

  typedef struct packed {
    logic [WORD_W-1:0] val;
    logic              ovf;
  } sat_res_t;

  // Signed product of two operands, computed on sign-extended copies.
  function automatic logic [PROD_W-1:0] smul(input logic [OP_W-1:0] a,
                                             input logic [OP_W-1:0] b);
    logic [PROD_W-1:0] ea, eb;
    ea = {{(PROD_W-OP_W){a[OP_W-1]}}, a};
    eb = {{(PROD_W-OP_W){b[OP_W-1]}}, b};
    return ea * eb;
  endfunction

  // Wide sum: low HI_BITS of hi concatenated with lo, plus extended product.
  function automatic logic [WIDE_W-1:0] wide_add(input logic [WORD_W-1:0] hi,
                                                 input logic [WORD_W-1:0] lo,
                                                 input logic [PROD_W-1:0] p);
    logic [WIDE_W-1:0] acc, ep;
    acc = {hi[HI_BITS-1:0], lo};
    ep  = {{(WIDE_W-PROD_W){p[PROD_W-1]}}, p};
    return acc + ep;
  endfunction

  // Clamped 32-bit signed sum with an overflow indication.
  function automatic sat_res_t sat_add(input logic [WORD_W-1:0] lo,
                                       input logic [PROD_W-1:0] p);
    logic [WORD_W:0] s;
    sat_res_t r;
    s = {lo[WORD_W-1], lo} + {{(WORD_W+1-PROD_W){p[PROD_W-1]}}, p};
    if (!s[WORD_W] && s[WORD_W-1]) begin
      r.val = {1'b0, {(WORD_W-1){1'b1}}};
      r.ovf = 1'b1;
    end else if (s[WORD_W] && !s[WORD_W-1]) begin
      r.val = {1'b1, {(WORD_W-1){1'b0}}};
      r.ovf = 1'b1;
    end else begin
      r.val = s[WORD_W-1:0];
      r.ovf = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
(
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] product
);
  assign product = smul(op_a, op_b);
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sat_mode,
  input  logic [PROD_W-1:0] product,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] acc_hi,
  output logic [WORD_W-1:0] acc_lo,
  output logic              clamp_evt
);
  logic [WIDE_W-1:0] wide_sum;
  sat_res_t          sat_sum;
  logic [WORD_W-1:0] hi_nxt, lo_nxt;

  assign wide_sum  = wide_add(acc_hi, acc_lo, product);
  assign sat_sum   = sat_add(acc_lo, product);
  assign clamp_evt = fire && sat_mode && sat_sum.ovf;

  always_comb begin
    hi_nxt = acc_hi;
    lo_nxt = acc_lo;
    if (hi_we || lo_we) begin
      if (hi_we) hi_nxt = wdata;
      if (lo_we) lo_nxt = wdata;
    end else if (fire) begin
      if (sat_mode) begin
        lo_nxt    = sat_sum.val;
        hi_nxt[0] = acc_hi[0] | sat_sum.ovf;
      end else begin
        lo_nxt = wide_sum[WORD_W-1:0];
        hi_nxt = {{EXT_W{wide_sum[WIDE_W-1]}}, wide_sum[WIDE_W-1:WORD_W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
    end else begin
      acc_hi <= hi_nxt;
      acc_lo <= lo_nxt;
    end
  end

  // R2
  wide_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && !sat_mode) |->
      acc_hi[WORD_W-1:HI_BITS] == {EXT_W{acc_hi[HI_BITS-1]}});

  // R3
  sat_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && sat_mode) |->
      acc_hi[WORD_W-1:1] == $past(acc_hi[WORD_W-1:1]));

  // R3
  clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clamp_evt) |->
      (acc_lo == {1'b0, {(WORD_W-1){1'b1}}} || acc_lo == {1'b1, {(WORD_W-1){1'b0}}}));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_hi[0] && !hi_we && sat_mode) |-> acc_hi[0]);

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clamp_evt) |-> acc_hi[0]);
endmodule

// File: rtl/mac_ptr.sv
module mac_ptr #(
  parameter int PTR_W    = 32,
  parameter int PTR_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_a_wdata,
  input  logic [PTR_W-1:0] ptr_b_wdata,
  output logic [PTR_W-1:0] ptr_a,
  output logic [PTR_W-1:0] ptr_b
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(PTR_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_a <= '0;
      ptr_b <= '0;
    end else if (ptr_we) begin
      ptr_a <= ptr_a_wdata;
      ptr_b <= ptr_b_wdata;
    end else if (fire) begin
      ptr_a <= ptr_a + STEP;
      ptr_b <= ptr_b + STEP;
    end
  end

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && !ptr_we) |->
      (ptr_a - $past(ptr_a) == STEP) && (ptr_b - $past(ptr_b) == STEP));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int PTR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sat_mode,
  input  logic              acc_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_a_wdata,
  input  logic [PTR_W-1:0]  ptr_b_wdata,
  output logic [WORD_W-1:0] acc_hi,
  output logic [WORD_W-1:0] acc_lo,
  output logic [PTR_W-1:0]  ptr_a,
  output logic [PTR_W-1:0]  ptr_b,
  output logic              done
);
  logic              any_write;
  logic              acc_fire;
  logic              clamp_evt;
  logic [PROD_W-1:0] product;

  assign any_write = hi_we | lo_we | ptr_we;
  assign acc_fire  = acc_valid & ~any_write;

  mac_mult u_mult (
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
  );

  mac_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (acc_fire),
    .sat_mode  (sat_mode),
    .product   (product),
    .hi_we     (hi_we),
    .lo_we     (lo_we),
    .wdata     (wdata),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .clamp_evt (clamp_evt)
  );

  mac_ptr #(.PTR_W(PTR_W), .PTR_STEP(PTR_STEP)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (acc_fire),
    .ptr_we      (ptr_we),
    .ptr_a_wdata (ptr_a_wdata),
    .ptr_b_wdata (ptr_b_wdata),
    .ptr_a       (ptr_a),
    .ptr_b       (ptr_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= acc_fire;
  end

  // R1
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc_valid));

  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && any_write) |-> !done);

  // R6
  cancel_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && (hi_we || lo_we) && !ptr_we) |-> $stable(ptr_a) && $stable(ptr_b));

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc_valid) |=> !done);
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sat_mode = 1'b0, acc_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        hi_we = 1'b0, lo_we = 1'b0, ptr_we = 1'b0;
  logic [31:0] wdata = '0, ptr_a_wdata = '0, ptr_b_wdata = '0;
  logic [31:0] acc_hi, acc_lo, ptr_a, ptr_b;
  logic        done;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_pa = '0, exp_pb = '0;

  always #5 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .acc_valid(acc_valid),
    .op_a(op_a), .op_b(op_b), .hi_we(hi_we), .lo_we(lo_we), .wdata(wdata),
    .ptr_we(ptr_we), .ptr_a_wdata(ptr_a_wdata), .ptr_b_wdata(ptr_b_wdata),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .ptr_a(ptr_a), .ptr_b(ptr_b), .done(done)
  );

  typedef struct packed {
    logic        sat;
    logic [31:0] hi, lo;
    logic [15:0] a, b;
    logic [31:0] ehi, elo;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,        32'h0,        16'h0003, 16'h0004, 32'h0,        32'h0000000C},
    '{1'b0, 32'h0,        32'h0,        16'hFFFE, 16'h0005, 32'hFFFFFFFF, 32'hFFFFFFF6},
    '{1'b0, 32'h0,        32'hFFFFFFFF, 16'h0001, 16'h0001, 32'h00000001, 32'h0},
    '{1'b0, 32'h000001FF, 32'hFFFFFFFF, 16'h0001, 16'h0001, 32'hFFFFFE00, 32'h0},
    '{1'b0, 32'h0,        32'h0,        16'h8000, 16'h8000, 32'h0,        32'h40000000},
    '{1'b1, 32'h0,        32'h7FFFFFF0, 16'h0010, 16'h0001, 32'h00000001, 32'h7FFFFFFF},
    '{1'b1, 32'h0,        32'h80000005, 16'hFFFF, 16'h0010, 32'h00000001, 32'h80000000},
    '{1'b1, 32'hABCD0000, 32'h00000064, 16'h0005, 16'hFFFD, 32'hABCD0000, 32'h00000055},
    '{1'b1, 32'h12345670, 32'h7FFFFFFF, 16'h0001, 16'h0001, 32'h12345671, 32'h7FFFFFFF},
    '{1'b1, 32'h00000001, 32'h0,        16'h0002, 16'h0003, 32'h00000001, 32'h00000006},
    '{1'b1, 32'hFFFFFFFE, 32'h40000000, 16'h8000, 16'h8000, 32'hFFFFFFFF, 32'h7FFFFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_hi(input logic [31:0] d);
    @(negedge clk); hi_we = 1'b1; wdata = d;
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic wr_lo(input logic [31:0] d);
    @(negedge clk); lo_we = 1'b1; wdata = d;
    @(negedge clk); lo_we = 1'b0;
  endtask

  // Pulse one accumulate; returns at the falling edge after the sampling edge.
  task automatic mac(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); acc_valid = 1'b1; op_a = a; op_b = b;
    @(negedge clk); acc_valid = 1'b0;
    exp_pa += 32'd2; exp_pb += 32'd2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 hi", acc_hi, 32'h0);
    chk("R7 lo", acc_lo, 32'h0);
    chk("R7 ptr_a", ptr_a, 32'h0);
    chk("R7 ptr_b", ptr_b, 32'h0);
    chk("R7 done", {31'b0, done}, 32'h0);
    rst_n = 1'b1;

    // R6 pointer load
    @(negedge clk); ptr_we = 1'b1; ptr_a_wdata = 32'h1000; ptr_b_wdata = 32'h2000;
    @(negedge clk); ptr_we = 1'b0;
    exp_pa = 32'h1000; exp_pb = 32'h2000;
    chk("R6 ptr_a load", ptr_a, exp_pa);

    // Vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      sat_mode = VEC[i].sat;
      wr_hi(VEC[i].hi);
      wr_lo(VEC[i].lo);
      mac(VEC[i].a, VEC[i].b);
      chk(VEC[i].sat ? "R3/R4 hi" : "R2 hi", acc_hi, VEC[i].ehi);
      chk(VEC[i].sat ? "R3 lo" : "R2 lo", acc_lo, VEC[i].elo);
      chk("R1 done high", {31'b0, done}, 32'h1);
      chk("R5 ptr_a", ptr_a, exp_pa);
      chk("R5 ptr_b", ptr_b, exp_pb);
      @(negedge clk);
      chk("R1 done one cycle", {31'b0, done}, 32'h0);
    end

    // R1 back-to-back accumulates in wide mode: 0 + 12 + 12
    sat_mode = 1'b0;
    wr_hi(32'h0); wr_lo(32'h0);
    @(negedge clk); acc_valid = 1'b1; op_a = 16'd3; op_b = 16'd4;
    @(negedge clk);
    @(negedge clk); acc_valid = 1'b0;
    exp_pa += 32'd4; exp_pb += 32'd4;
    chk("R1 back-to-back lo", acc_lo, 32'd24);
    chk("R5 back-to-back ptr_a", ptr_a, exp_pa);

    // R4 sticky flag cleared by high-word write, then stays clear with no clamp
    sat_mode = 1'b1;
    wr_hi(32'h1); wr_lo(32'h7FFFFFFF);
    mac(16'h0001, 16'h0001);
    chk("R4 sticky held", acc_hi, 32'h1);
    wr_hi(32'h0);
    chk("R4 cleared by write", acc_hi, 32'h0);
    wr_lo(32'h0);
    mac(16'h0002, 16'h0002);
    chk("R4 no clamp no flag", acc_hi, 32'h0);
    chk("R3 in-range sum", acc_lo, 32'd4);

    // R6 write collides with accumulate: write wins, accumulate dropped
    @(negedge clk); lo_we = 1'b1; wdata = 32'h7; acc_valid = 1'b1; op_a = 16'd9; op_b = 16'd9;
    @(negedge clk); lo_we = 1'b0; acc_valid = 1'b0;
    chk("R6 write wins lo", acc_lo, 32'h7);
    chk("R6 no done", {31'b0, done}, 32'h0);
    chk("R6 ptr_a unchanged", ptr_a, exp_pa);
    chk("R6 hi unchanged", acc_hi, 32'h0);

    // R5 pointer wrap
    @(negedge clk); ptr_we = 1'b1; ptr_a_wdata = 32'hFFFFFFFE; ptr_b_wdata = 32'hFFFFFFFF;
    @(negedge clk); ptr_we = 1'b0;
    exp_pa = 32'hFFFFFFFE; exp_pb = 32'hFFFFFFFF;
    mac(16'h0001, 16'h0001);
    chk("R5 wrap ptr_a", ptr_a, 32'h0);
    chk("R5 wrap ptr_b", ptr_b, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule